// File: doc/BRIEF.md
# Multidrop Serial Receiver with Mute and Wake-up

This block receives asynchronous serial characters on one line for a multidrop link where several receivers share one bus. Each character has a start bit (low), a payload sent least significant bit first, and a stop bit (high). The payload is 8 or 9 bits, and its top bit can optionally serve as a parity bit. The line is sampled on a 16x oversampling enable. Each bit value is the majority of three samples taken around mid-bit. Received characters leave on a valid/ready stream, with their parity-error and framing-error flags held beside the data.

Software can put the receiver to sleep with a mute request. While muted, the receiver delivers no character, raises no idle flag and holds its interrupt low. It leaves mute in one of two ways, chosen by the wake-method input. On an idle line it wakes silently, with no idle flag. On an address character, whose top data bit is 1, it wakes and delivers that character as ordinary data. This lets receivers that are not addressed ignore the rest of a message.

Back-pressure: a character is held on `rx_data` with `rx_valid` high until a cycle with `rx_ready` high. A character that completes while a held one is still not accepted is dropped, together with its flags. When `rx_ready` is high in the same cycle a new character completes, the new character replaces the old one.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rx_valid`, `idle_flag`, `irq` and `muted` are all 0.
- R2: `long_word`=0 gives 8 payload bits and `long_word`=1 gives 9, received least significant bit first. With `par_en`=1 the top payload bit is parity and the data is one bit shorter. Data appears in `rx_data` bit 0 upward, and unused upper bits are 0.
- R3: With `par_en`=1, `rx_perr` is 1 when the number of ones in data plus parity is odd (`par_odd`=0) or even (`par_odd`=1). With `par_en`=0, `rx_perr` is 0.
- R4: A stop bit that is sampled low sets `rx_ferr` for that character.
- R5: A start bit whose mid-bit majority vote is high is treated as noise, and no character results from it.
- R6: `idle_flag` pulses for one cycle when the line stays high for one full character time (10 + `long_word` bit periods), counted from the middle of a stop bit or from reset. It pulses only once per such quiet period.
- R7: A one-cycle `mute_req` sets `muted`. While muted, no character is delivered except a waking address character, `idle_flag` stays 0, and `irq` stays low.
- R8: With `wake_addr`=0, an idle line while muted clears `muted` and does not pulse `idle_flag`. Characters received while muted are dropped and do not wake the receiver.
- R9: With `wake_addr`=1, a character whose top data bit (never the parity bit) is 1 clears `muted` and is delivered. Other characters, including a break (all zeros with the stop bit low), are dropped, and idle lines do not wake the receiver.
- R10: `rx_valid` and `rx_data` hold while `rx_ready` is 0. A character arriving meanwhile is dropped, and `rx_valid` falls after a cycle with `rx_ready` high.
- R11: `irq` is 1 exactly when `rx_valid` is 1 or `idle_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| rx | input | 1 | Serial receive line, idle high |
| mute_req | input | 1 | One-cycle request to enter mute |
| wake_addr | input | 1 | Wake method: 0 idle line, 1 address character |
| par_en | input | 1 | Top payload bit is parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| long_word | input | 1 | 0: 8 payload bits, 1: 9 payload bits |
| rx_data | output | 9 | Received data, zero-extended |
| rx_valid | output | 1 | Stream valid |
| rx_ready | input | 1 | Stream ready |
| rx_perr | output | 1 | Parity error of the held character |
| rx_ferr | output | 1 | Framing error of the held character |
| idle_flag | output | 1 | One-cycle idle-line pulse |
| muted | output | 1 | Receiver is in mute |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. No character is delivered while muted unless an address character wakes the receiver. An idle wake clears mute without an idle pulse. An address wake leaves valid data with mute cleared. Held data stays stable under back-pressure. The bench scenarios are the only way to show that each format and parity setting decodes to the right value, that noise starts and broken stop bits are handled, that the idle timer waits one full character time and fires once, and that a parity bit of 1 never counts as an address mark.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  localparam int PAYW = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  function automatic logic [3:0] payload_bits(input logic long_word);
    return long_word ? 4'd9 : 4'd8;
  endfunction

  function automatic logic [3:0] data_bits(input logic long_word, input logic par_en);
    return payload_bits(long_word) - {3'd0, par_en};
  endfunction

  function automatic logic [3:0] frame_bits(input logic long_word);
    return payload_bits(long_word) + 4'd2;
  endfunction
endpackage

// File: rtl/mp_rx_vote.sv
module mp_rx_vote #(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxs,
  input  logic [CW-1:0] phase,
  output logic          vote
);
  localparam logic [CW-1:0] P_A = CW'(OVS/2 - 2);
  localparam logic [CW-1:0] P_B = CW'(OVS/2 - 1);

  logic s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (phase == P_A) s_a <= rxs;
      if (phase == P_B) s_b <= rxs;
    end
  end

  // third sample is the live line at the centre phase
  assign vote = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);
endmodule

// File: rtl/mp_rx_frame.sv
module mp_rx_frame
  import mp_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxs,
  input  logic            long_word,
  output logic            done,
  output logic [PAYW-1:0] payload,
  output logic            stop_ok
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2);
  localparam logic [CW-1:0] LAST = CW'(OVS-1);

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [3:0]      bidx;
  logic            vote;

  mp_rx_vote #(.OVS(OVS)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs), .phase(cnt), .vote(vote)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      payload <= '0;
      stop_ok <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: if (!rxs) begin
            state   <= ST_START;
            cnt     <= CW'(1);
            payload <= '0;
          end
          ST_START: begin
            cnt <= cnt + 1'b1;
            if (cnt == MID && vote) state <= ST_IDLE;
            else if (cnt == LAST) begin
              state <= ST_DATA;
              cnt   <= '0;
              bidx  <= '0;
            end
          end
          ST_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == MID) payload[bidx] <= vote;
            if (cnt == LAST) begin
              cnt <= '0;
              if (bidx == payload_bits(long_word) - 4'd1) state <= ST_STOP;
              else bidx <= bidx + 4'd1;
            end
          end
          ST_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == MID) begin
              done    <= 1'b1;
              stop_ok <= vote;
              state   <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mp_rx_idle.sv
module mp_rx_idle
  import mp_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxs,
  input  logic arm,
  input  logic long_word,
  output logic idle_p
);
  localparam int CNTW = $clog2(OVS*12 + 1);

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] limit;
  logic            armed;

  assign limit = CNTW'(frame_bits(long_word)) * CNTW'(OVS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      armed  <= 1'b1;
      idle_p <= 1'b0;
    end else begin
      idle_p <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (tick) begin
        if (!rxs) cnt <= '0;
        else if (armed) begin
          if (cnt == limit - 1'b1) begin
            idle_p <= 1'b1;
            armed  <= 1'b0;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r6_idle_once: assert property (@(posedge clk) disable iff (!rst_n)
    idle_p |=> !idle_p);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       mute_req,
  input  logic       wake_addr,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       long_word,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       idle_flag,
  output logic       muted,
  output logic       irq
);
  logic            rx_m, rxs;
  logic            done, stop_ok, idle_p;
  logic [PAYW-1:0] payload;
  logic [PAYW-1:0] dmask, pmask;
  logic [3:0]      nd, np;
  logic            addr_bit, perr_c, addr_hit, deliver, can_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rxs  <= 1'b1;
    end else begin
      rx_m <= rx;
      rxs  <= rx_m;
    end
  end

  mp_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs), .long_word(long_word),
    .done(done), .payload(payload), .stop_ok(stop_ok)
  );

  mp_rx_idle #(.OVS(OVS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs), .arm(done),
    .long_word(long_word), .idle_p(idle_p)
  );

  always_comb begin
    nd = data_bits(long_word, par_en);
    np = payload_bits(long_word);
    for (int i = 0; i < PAYW; i++) begin
      dmask[i] = (4'(i) < nd);
      pmask[i] = (4'(i) < np);
    end
    addr_bit = payload[nd - 4'd1];
    perr_c   = par_en & ((^(payload & pmask)) != par_odd);
  end

  assign addr_hit = done & wake_addr & addr_bit & muted;
  assign deliver  = done & (!muted | addr_hit);
  assign can_load = !rx_valid | rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      muted     <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_perr   <= 1'b0;
      rx_ferr   <= 1'b0;
      idle_flag <= 1'b0;
    end else begin
      if (mute_req) muted <= 1'b1;
      else if ((idle_p && !wake_addr) || addr_hit) muted <= 1'b0;

      if (deliver && can_load) begin
        rx_valid <= 1'b1;
        rx_data  <= payload & dmask;
        rx_perr  <= perr_c;
        rx_ferr  <= !stop_ok;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end

      idle_flag <= idle_p & !muted;
    end
  end

  assign irq = rx_valid | idle_flag;

  a_r7_no_valid_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !addr_hit) |=> !$rose(rx_valid));
  a_r7_no_idle_muted: assert property (@(posedge clk) disable iff (!rst_n)
    muted |=> !idle_flag);
  a_r8_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !wake_addr && idle_p && !mute_req) |=> (!muted && !idle_flag));
  a_r9_addr_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && wake_addr && done && addr_bit && !mute_req && can_load) |=> (rx_valid && !muted));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic mute_req = 1'b0, wake_addr = 1'b0, par_en = 1'b0, par_odd = 1'b0, long_word = 1'b0;
  logic rx_ready = 1'b0;
  logic [8:0] rx_data;
  logic rx_valid, rx_perr, rx_ferr, idle_flag, muted, irq;

  int checks = 0;
  int errors = 0;
  int idle_cnt = 0;
  int irq_bad = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) tick <= ~tick;  // 16 ticks per bit = 32 clocks

  always @(posedge clk) begin
    if (idle_flag) idle_cnt <= idle_cnt + 1;
    if (irq !== (rx_valid | idle_flag)) irq_bad <= irq_bad + 1;
  end

  mp_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .mute_req(mute_req),
    .wake_addr(wake_addr), .par_en(par_en), .par_odd(par_odd), .long_word(long_word),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .idle_flag(idle_flag), .muted(muted), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] pay, input int nb, input logic stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(pay[i]);
    drive_bit(stop_v);
    rx = 1'b1;
  endtask

  task automatic settle();
    rx = 1'b1;
    repeat (500) @(negedge clk);
  endtask

  task automatic accept();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic lw, input logic pe, input logic po, input logic wa);
    long_word = lw; par_en = pe; par_odd = po; wake_addr = wa;
    @(negedge clk);
  endtask

  task automatic do_mute();
    mute_req = 1'b1;
    @(negedge clk);
    mute_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1 valid", rx_valid, 0);
    chk("R1 muted", muted, 0);
    chk("R1 irq", irq, 0);
    chk("R1 idle", idle_flag, 0);
    rst_n = 1'b1;
    settle();
    chk("R6 idle after reset", idle_cnt, 1);
  endtask

  task automatic t_basic_and_idle();
    int snap;
    cfg(0, 0, 0, 0);
    snap = idle_cnt;
    send(9'h0A5, 8, 1);
    chk("R2 valid 8bit", rx_valid, 1);
    chk("R2 data 8bit", rx_data, 9'h0A5);
    chk("R3 no perr", rx_perr, 0);
    chk("R4 no ferr", rx_ferr, 0);
    chk("R11 irq with data", irq, 1);
    accept();
    chk("R10 valid drops", rx_valid, 0);
    chk("R11 irq low", irq, 0);
    repeat (240) @(negedge clk);
    chk("R6 no early idle", idle_cnt, snap);
    settle();
    chk("R6 idle after char", idle_cnt, snap + 1);
    settle();
    chk("R6 idle once", idle_cnt, snap + 1);
  endtask

  task automatic t_parity();
    cfg(0, 1, 0, 0);
    send(9'h035, 8, 1);
    chk("R3 even ok data", rx_data, 9'h035);
    chk("R3 even ok perr", rx_perr, 0);
    accept();
    send(9'h0B5, 8, 1);
    chk("R3 even bad data", rx_data, 9'h035);
    chk("R3 even bad perr", rx_perr, 1);
    accept();
    cfg(0, 1, 1, 0);
    send(9'h0B5, 8, 1);
    chk("R3 odd ok perr", rx_perr, 0);
    accept();
    cfg(1, 0, 0, 0);
    send(9'h1C3, 9, 1);
    chk("R2 data 9bit", rx_data, 9'h1C3);
    chk("R3 perr off", rx_perr, 0);
    accept();
    cfg(1, 1, 1, 0);
    send(9'h181, 9, 1);
    chk("R2 data 8+par", rx_data, 9'h081);
    chk("R3 odd 9bit perr", rx_perr, 0);
    accept();
    settle();
  endtask

  task automatic t_frame_noise();
    cfg(0, 0, 0, 0);
    send(9'h03C, 8, 0);
    chk("R4 ferr", rx_ferr, 1);
    chk("R4 data", rx_data, 9'h03C);
    accept();
    settle();
    rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (400) @(negedge clk);
    chk("R5 noise no char", rx_valid, 0);
    send(9'h05A, 8, 1);
    chk("R5 recover data", rx_data, 9'h05A);
    accept();
    settle();
  endtask

  task automatic t_mute_idle();
    int snap;
    cfg(0, 0, 0, 0);
    do_mute();
    chk("R7 muted set", muted, 1);
    snap = idle_cnt;
    send(9'h077, 8, 1);
    chk("R7 no deliver", rx_valid, 0);
    chk("R7 irq low", irq, 0);
    chk("R8 char no wake", muted, 1);
    settle();
    chk("R8 idle wakes", muted, 0);
    chk("R8 no idle flag", idle_cnt, snap);
    send(9'h042, 8, 1);
    chk("R8 deliver after wake", rx_data, 9'h042);
    accept();
    settle();
  endtask

  task automatic t_mute_addr();
    int snap;
    cfg(0, 0, 0, 1);
    do_mute();
    snap = idle_cnt;
    send(9'h012, 8, 1);
    chk("R9 plain dropped", rx_valid, 0);
    send(9'h000, 8, 0);
    chk("R9 break dropped", rx_valid, 0);
    chk("R9 break no wake", muted, 1);
    settle();
    chk("R9 idle no wake", muted, 1);
    chk("R7 idle suppressed", idle_cnt, snap);
    send(9'h085, 8, 1);
    chk("R9 addr valid", rx_valid, 1);
    chk("R9 addr data", rx_data, 9'h085);
    chk("R9 addr wakes", muted, 0);
    accept();
    settle();
    cfg(0, 1, 0, 1);
    do_mute();
    send(9'h085, 8, 1);
    chk("R9 parity bit not addr", rx_valid, 0);
    chk("R9 parity still muted", muted, 1);
    send(9'h0C5, 8, 1);
    chk("R9 msb addr data", rx_data, 9'h045);
    chk("R9 msb addr perr", rx_perr, 0);
    chk("R9 msb addr wakes", muted, 0);
    accept();
    settle();
  endtask

  task automatic t_backpressure();
    cfg(0, 0, 0, 0);
    send(9'h011, 8, 1);
    send(9'h022, 8, 1);
    chk("R10 held valid", rx_valid, 1);
    chk("R10 held data", rx_data, 9'h011);
    accept();
    repeat (20) @(negedge clk);
    chk("R10 second dropped", rx_valid, 0);
    settle();
    chk("R11 irq matches", irq_bad, 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_basic_and_idle();
    t_parity();
    t_frame_noise();
    t_mute_idle();
    t_mute_addr();
    t_backpressure();
    done_flag = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end
endmodule